// File: doc/BRIEF.md
# FFT Stage Read-Address and Twiddle-Address Generator

This block drives the read side of one radix-2 FFT stage. The data samples of a stage sit in two banks, A and B. Each read step fetches one word from each bank at a common read address, and one twiddle factor from a ROM. The block counts these steps and produces three results for each step: the bank read address, the twiddle ROM address, and a swap select. The swap select tells the datapath which bank supplies butterfly operand a and which supplies operand b.

The controller pulses `stage_init_i` once at the start of each stage. It holds `stage_i` at the stage number, counted from 1 up to log2(N). It raises `rd_req_i` for one cycle per read step. The results for a step appear, registered, in the cycle after the strobe, marked by `out_valid_o`. The datapath takes every result as it arrives, so there is no back-pressure: no ready input exists, and a strobe is never stalled. When no strobe arrives, the outputs hold their last values.

Top module: `fftag_addr_gen`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid_o` is 0 and `data_addr_o`, `tw_addr_o` and `swap_o` are all 0. A reset leaves the internal state exactly as a stage init does.
- R2: The first read after a stage init returns data address 0, twiddle address 0 and `swap_o` = 0.
- R3: Each later read in the same stage returns a data address one higher than the previous read. The address is log2(N)-1 bits wide and wraps from N/2-1 to 0.
- R4: `swap_o` alternates on each read, starting at 0. A value of 0 means operand a comes from bank A and operand b from bank B. A value of 1 means operand a comes from bank B and operand b from bank A.
- R5: The twiddle address of read k after init is the sum of (N >> s) over the previous reads, taken modulo N/2. Here s is the value on `stage_i` at each of those reads, and s must lie in 1..log2(N) whenever `rd_req_i` is high.
- R6: `out_valid_o` is high in exactly the cycles that follow a cycle with `rd_req_i` high.
- R7: In a cycle without a read strobe, nothing advances. The outputs keep their values, and the next read continues the same sequence.
- R8: When `stage_init_i` and `rd_req_i` are high in the same cycle, that read is served as the first read of the new stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_init_i | input | 1 | One-cycle pulse marking the start of a stage |
| rd_req_i | input | 1 | Read step strobe |
| stage_i | input | $clog2(log2(N)+1) | Current stage number, 1..log2(N) |
| out_valid_o | output | 1 | Results of the previous cycle's strobe are present |
| data_addr_o | output | log2(N)-1 | Read address for both data banks |
| tw_addr_o | output | log2(N)-1 | Twiddle ROM address |
| swap_o | output | 1 | 1 selects bank B for operand a and bank A for operand b |

## Verification
A corrupted data counter or parity bit shows at the ports on the very next strobe, one cycle later. It appears as an address step other than +1 or as two equal swap values in a row. A corrupted twiddle accumulator is hidden in stage 1, where every stride is 0 modulo N/2. Stages with smaller strides expose it within one read. A failure to clear on init shows on the first valid output after the init.

// File: rtl/fftag_pkg.sv
package fftag_pkg;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } parity_e;

  function automatic int unsigned lg2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

endpackage

// File: rtl/fftag_step_acc.sv
module fftag_step_acc #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] serve_o
);

  logic [W-1:0] acc_q;

  // A clear in the same cycle as an advance serves the cleared value.
  assign serve_o = clr_i ? '0 : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (adv_i) begin
      acc_q <= serve_o + step_i;
    end else if (clr_i) begin
      acc_q <= '0;
    end
  end

endmodule

// File: rtl/fftag_stride.sv
module fftag_stride #(
  parameter int N_POINTS = 64,
  parameter int AW       = 5,
  parameter int SW       = 3
) (
  input  logic [SW-1:0] stage_i,
  output logic [AW-1:0] step_o
);

  localparam int unsigned NP = N_POINTS;

  // N >> stage, truncated to the address width (modulo N/2).
  always_comb begin
    step_o = AW'(NP >> stage_i);
  end

endmodule

// File: rtl/fftag_out_reg.sv
module fftag_out_reg #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] tw_i,
  input  logic          swap_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] tw_o,
  output logic          swap_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      tw_o    <= '0;
      swap_o  <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        addr_o <= addr_i;
        tw_o   <= tw_i;
        swap_o <= swap_i;
      end
    end
  end

endmodule

// File: rtl/fftag_addr_gen.sv
module fftag_addr_gen
  import fftag_pkg::*;
#(
  parameter int N_POINTS = 64,
  localparam int LOG2N   = lg2(N_POINTS),
  localparam int AW      = LOG2N - 1,
  localparam int SW      = lg2(LOG2N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_init_i,
  input  logic          rd_req_i,
  input  logic [SW-1:0] stage_i,
  output logic          out_valid_o,
  output logic [AW-1:0] data_addr_o,
  output logic [AW-1:0] tw_addr_o,
  output logic          swap_o
);

  logic [AW-1:0] tw_step;
  logic [AW-1:0] data_serve;
  logic [AW-1:0] tw_serve;
  logic [0:0]    par_serve;
  parity_e       par_now;

  fftag_stride #(
    .N_POINTS(N_POINTS),
    .AW      (AW),
    .SW      (SW)
  ) u_stride (
    .stage_i(stage_i),
    .step_o (tw_step)
  );

  // Data read address: step of one per read.
  fftag_step_acc #(.W(AW)) u_data_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (stage_init_i),
    .adv_i  (rd_req_i),
    .step_i (AW'(1)),
    .serve_o(data_serve)
  );

  // Twiddle offset, kept already reduced modulo N/2.
  fftag_step_acc #(.W(AW)) u_tw_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (stage_init_i),
    .adv_i  (rd_req_i),
    .step_i (tw_step),
    .serve_o(tw_serve)
  );

  // Cycle parity: a one-bit accumulator stepping by one.
  fftag_step_acc #(.W(1)) u_par_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (stage_init_i),
    .adv_i  (rd_req_i),
    .step_i (1'b1),
    .serve_o(par_serve)
  );

  assign par_now = parity_e'(par_serve[0]);

  fftag_out_reg #(.AW(AW)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (rd_req_i),
    .addr_i (data_serve),
    .tw_i   (tw_serve),
    .swap_i (par_now == PAR_ODD),
    .valid_o(out_valid_o),
    .addr_o (data_addr_o),
    .tw_o   (tw_addr_o),
    .swap_o (swap_o)
  );

endmodule

// File: rtl/fftag_addr_gen_chk.sv
module fftag_addr_gen_chk #(
  parameter int N_POINTS = 64,
  parameter int LOG2N    = 6,
  parameter int AW       = 5,
  parameter int SW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stage_init_i,
  input logic          rd_req_i,
  input logic [SW-1:0] stage_i,
  input logic          out_valid_o,
  input logic [AW-1:0] data_addr_o,
  input logic [AW-1:0] tw_addr_o,
  input logic          swap_o
);

  logic          pend_q;
  logic          fresh_q;
  logic [AW-1:0] last_addr_q;
  logic          last_swap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b1;
      fresh_q     <= 1'b0;
      last_addr_q <= '0;
      last_swap_q <= 1'b0;
    end else begin
      if (rd_req_i)          pend_q <= 1'b0;
      else if (stage_init_i) pend_q <= 1'b1;
      fresh_q <= stage_init_i | pend_q;
      if (out_valid_o) begin
        last_addr_q <= data_addr_o;
        last_swap_q <= swap_o;
      end
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> out_valid_o);

  assert_valid_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !out_valid_o);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> ($stable(data_addr_o) && $stable(tw_addr_o) && $stable(swap_o)));

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && fresh_q) |-> (data_addr_o == '0 && tw_addr_o == '0 && !swap_o));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !fresh_q) |-> (data_addr_o == AW'(last_addr_q + 1'b1)));

  assert_swap_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !fresh_q) |-> (swap_o != last_swap_q));

  assert_stage_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |-> (stage_i >= SW'(1) && stage_i <= SW'(LOG2N)));

endmodule

bind fftag_addr_gen fftag_addr_gen_chk #(
  .N_POINTS(N_POINTS),
  .LOG2N   (LOG2N),
  .AW      (AW),
  .SW      (SW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stage_init_i(stage_init_i),
  .rd_req_i    (rd_req_i),
  .stage_i     (stage_i),
  .out_valid_o (out_valid_o),
  .data_addr_o (data_addr_o),
  .tw_addr_o   (tw_addr_o),
  .swap_o      (swap_o)
);

// File: tb/fftag_addr_gen_test.sv
module fftag_addr_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;
  localparam int LG = 6;
  localparam int AW = 5;
  localparam int SW = 3;
  localparam int HALF = NP / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [SW-1:0] stg = SW'(1);
  logic          vld;
  logic [AW-1:0] daddr;
  logic [AW-1:0] taddr;
  logic          swp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Model state, built from the requirements.
  int  m_addr = 0;
  int  m_tw = 0;
  bit  m_par = 1'b0;
  bit  m_fresh = 1'b1;
  bit  e_vld = 1'b0;
  int  e_addr = 0;
  int  e_tw = 0;
  bit  e_swp = 1'b0;

  fftag_addr_gen #(.N_POINTS(NP)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_init_i(init_i),
    .rd_req_i    (rd_i),
    .stage_i     (stg),
    .out_valid_o (vld),
    .data_addr_o (daddr),
    .tw_addr_o   (taddr),
    .swap_o      (swp)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int stride_of(input int s);
    return (NP >> s) % HALF;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit i, input bit r, input int s);
    string at;
    @(negedge clk);
    init_i = i;
    rd_i   = r;
    stg    = SW'(s);
    if (r) begin
      at = i ? "R8" : (m_fresh ? "R2" : "R3");
      if (i) begin
        m_addr = 0; m_tw = 0; m_par = 1'b0;
      end
      e_vld  = 1'b1;
      e_addr = m_addr;
      e_tw   = m_tw;
      e_swp  = m_par;
      m_addr = (m_addr + 1) % HALF;
      m_tw   = (m_tw + stride_of(s)) % HALF;
      m_par  = ~m_par;
      m_fresh = 1'b0;
    end else begin
      at = "R7";
      e_vld = 1'b0;
      if (i) begin
        m_addr = 0; m_tw = 0; m_par = 1'b0; m_fresh = 1'b1;
      end
    end
    @(posedge clk);
    #(CLK_PERIOD / 4);
    chk("R6", "valid", int'(vld), int'(e_vld));
    chk(at, "data_addr", int'(daddr), e_addr);
    chk(r ? (i ? "R8" : "R5") : "R7", "tw_addr", int'(taddr), e_tw);
    chk(r ? (i ? "R8" : "R4") : "R7", "swap", int'(swp), int'(e_swp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s;
    void'($urandom(32'h5eed_0f17));
    // R1: reset state
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 4);
    chk("R1", "valid in reset", int'(vld), 0);
    chk("R1", "addr in reset", int'(daddr), 0);
    chk("R1", "tw in reset", int'(taddr), 0);
    chk("R1", "swap in reset", int'(swp), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    chk("R1", "valid after reset", int'(vld), 0);

    // R1/R2: reads straight after reset, stage 3, no init
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 3);

    // R3/R4/R5: full stage 4 plus wrap past N/2-1
    step(1'b1, 1'b0, 4);
    for (int k = 0; k < HALF + 3; k++) step(1'b0, 1'b1, 4);

    // R7: idle gaps keep outputs and state
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 4);
    step(1'b0, 1'b1, 4);

    // R8: init with read in same cycle, stage 6 (stride 1)
    step(1'b1, 1'b1, 6);
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 6);

    // R5: stage 1 keeps twiddle at 0
    step(1'b1, 1'b0, 1);
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 1);

    // Random mix
    s = 2;
    for (int k = 0; k < 3000; k++) begin
      bit ri;
      bit ii;
      ii = ($urandom % 40) == 0;
      ri = ($urandom % 4) != 0;
      if (ii) s = 1 + int'($urandom % LG);
      step(ii, ri, s);
    end

    @(negedge clk);
    rd_i = 1'b0;
    init_i = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule